// File: doc/BRIEF.md
# Point-to-Point Link Receiver with Flow Acknowledge

This block terminates one receive link of a point-to-point interconnect. The transmitter forwards a link clock together with a narrow data bus. The receiver samples one unit of data on each falling edge of that clock. The link clock is taken into the core clock domain through a short synchronizer, and the data bus goes through a matched pipeline so that both arrive aligned. Units are packed most-significant first into a 32-bit or 48-bit word. The unit is the low 4 bits of the data bus or all 8 of them, chosen by configuration.

Each finished word enters a two-entry receive buffer. The buffer is drained through a valid/ready read port, and back-pressure is plain: a reader that raises `rd_ready` while the buffer is empty waits, and the head word stays on `rd_data` until it is accepted. The receiver drives an acknowledge line back to the transmitter. Acknowledge is high only when the port is enabled, the buffer has room and no post-word hold is running. The transmitter starts a new word only while acknowledge is high.

After every 48-bit word, acknowledge drops for a fixed number of core cycles. A service request flags a non-empty buffer to the core whenever a DMA engine does not own the port. Clearing the enable drops any partly assembled word.

Top module: `link_rx_ack`

## Requirements
- R1: After reset with `cfg_enable` high, `lnk_ack` is 1, `rd_valid` is 0, `rd_empty` is 1 and `srq` is 0.
- R2: A unit is captured only at a falling edge of `lnk_clk`. Values on `lnk_data` while `lnk_clk` is high are ignored if they are replaced before the falling edge.
- R3: With a 4-bit path (`cfg_wide_path`=0, unit = `lnk_data[3:0]`) and 32-bit words (`cfg_long_word`=0), eight units make one word, and the first unit lands in bits 31:28.
- R4: With an 8-bit path, a 32-bit word takes 4 units and a 48-bit word takes 6 units; a 48-bit word on a 4-bit path takes 12 units. A 32-bit word appears on `rd_data` with bits 47:32 zero.
- R5: The buffer holds two words and returns them in arrival order. `lnk_ack` is 0 while two words are held and returns to 1 after one is read.
- R6: `rd_valid` is 0 while the buffer is empty, and `rd_ready` then has no effect. While `rd_valid` is 1 and `rd_ready` is 0, `rd_data` holds its value.
- R7: After each 48-bit word, `lnk_ack` is 0 for exactly HOLD_CYC (default 2) core cycles even though the buffer has room. After a 32-bit word it does not drop.
- R8: `srq` is 1 exactly when the buffer is non-empty and `dma_active` is 0.
- R9: While `cfg_enable` is 0, `lnk_ack` is 0 and any partly received word is discarded. The next word after re-enable is assembled from its own units only.
- R10: `rd_empty` is 1 exactly when the buffer holds no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Port enable; low flushes a partial word |
| cfg_long_word | input | 1 | 1 = 48-bit words, 0 = 32-bit words |
| cfg_wide_path | input | 1 | 1 = 8-bit units, 0 = 4-bit units on bits 3:0 |
| dma_active | input | 1 | High when a DMA engine owns the port (masks `srq`) |
| lnk_clk | input | 1 | Forwarded link clock from the transmitter |
| lnk_data | input | 8 | Link data, sampled on the falling edge of `lnk_clk` |
| lnk_ack | output | 1 | Acknowledge to the transmitter |
| rd_valid | output | 1 | Head word available |
| rd_ready | input | 1 | Reader accepts the head word |
| rd_data | output | 48 | Head word, zero-extended in 32-bit mode |
| rd_empty | output | 1 | Buffer holds no word |
| srq | output | 1 | Service request for a non-empty buffer |

## Verification
The assertions assume that the transmitter keeps to the acknowledge protocol. It starts a word only while `lnk_ack` is high, holds each level of `lnk_clk` for several core cycles and leaves the configuration unchanged inside a word. If those hold, a finished word never meets a full buffer. The stimulus waits for acknowledge before every word and uses four-cycle link clock phases, with data stable through the low phase. Word size and path width change only between words, while the link clock is low.

// File: rtl/lrx_pkg.sv
package lrx_pkg;

  // number of link units that make up one word
  function automatic int unsigned lrx_units(input int unsigned word_w,
                                            input int unsigned unit_w);
    return word_w / unit_w;
  endfunction

endpackage

// File: rtl/lrx_edge_sync.sv
module lrx_edge_sync #(
  parameter int STAGES = 2,
  parameter int UNIT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lnk_clk,
  input  logic [UNIT_W-1:0] lnk_data,
  output logic              fall_stb,
  output logic [UNIT_W-1:0] unit_data
);

  logic [STAGES-1:0] clk_pipe;
  logic [UNIT_W-1:0] dat_pipe [STAGES];
  logic              clk_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_pipe    <= '0;
      dat_pipe[0] <= '0;
      clk_prev    <= 1'b0;
    end else begin
      clk_pipe[0] <= lnk_clk;
      dat_pipe[0] <= lnk_data;
      clk_prev    <= clk_pipe[STAGES-1];
    end
  end

  // data travels alongside the clock so both reach the edge detector together
  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        clk_pipe[s] <= 1'b0;
        dat_pipe[s] <= '0;
      end else begin
        clk_pipe[s] <= clk_pipe[s-1];
        dat_pipe[s] <= dat_pipe[s-1];
      end
    end
  end

  assign fall_stb  = clk_prev & ~clk_pipe[STAGES-1];
  assign unit_data = dat_pipe[STAGES-1];

endmodule

// File: rtl/lrx_assembler.sv
module lrx_assembler
  import lrx_pkg::*;
#(
  parameter int LONG_W   = 48,
  parameter int SHORT_W  = 32,
  parameter int UNIT_W   = 8,
  parameter int NARROW_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              long_word,
  input  logic              wide_path,
  input  logic              unit_stb,
  input  logic [UNIT_W-1:0] unit_data,
  output logic              word_vld,
  output logic              word_long,
  output logic [LONG_W-1:0] word_data
);

  localparam int MAX_UNITS = LONG_W / NARROW_W;
  localparam int CW        = $clog2(MAX_UNITS + 1);
  localparam logic [LONG_W-1:0] SHORT_MASK =
    {{(LONG_W-SHORT_W){1'b0}}, {SHORT_W{1'b1}}};

  logic [CW-1:0]     cnt;
  logic [CW-1:0]     last_idx;
  logic [LONG_W-1:0] shreg;
  logic [LONG_W-1:0] shift_nx;

  always_comb begin
    last_idx = CW'(lrx_units(long_word ? LONG_W : SHORT_W,
                             wide_path ? UNIT_W : NARROW_W) - 1);
    if (wide_path) shift_nx = {shreg[LONG_W-UNIT_W-1:0], unit_data};
    else           shift_nx = {shreg[LONG_W-NARROW_W-1:0], unit_data[NARROW_W-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      shreg     <= '0;
      word_vld  <= 1'b0;
      word_long <= 1'b0;
      word_data <= '0;
    end else begin
      word_vld <= 1'b0;
      if (!enable) begin
        cnt   <= '0;
        shreg <= '0;
      end else if (unit_stb) begin
        if (cnt == last_idx) begin
          cnt       <= '0;
          shreg     <= '0;
          word_vld  <= 1'b1;
          word_long <= long_word;
          word_data <= long_word ? shift_nx : (shift_nx & SHORT_MASK);
        end else begin
          cnt   <= cnt + 1'b1;
          shreg <= shift_nx;
        end
      end
    end
  end

  p_flush_on_disable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (cnt == '0));

  p_single_word_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |=> !word_vld);

endmodule

// File: rtl/lrx_fifo2.sv
module lrx_fifo2 #(
  parameter int WIDTH = 48,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data,
  output logic             full,
  output logic             empty
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;
  logic             pop;

  assign empty     = (count == '0);
  assign full      = (count == CW'(DEPTH));
  assign out_valid = ~empty;
  assign out_data  = mem[rd_ptr];
  assign pop       = out_valid & out_ready;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push && !full) wr_ptr <= bump(wr_ptr);
      if (pop)           rd_ptr <= bump(rd_ptr);
      case ({push && !full, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                      mem[e] <= '0;
      else if (push && !full && wr_ptr == PW'(e))      mem[e] <= push_data;
    end
  end

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push);

  p_head_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/lrx_ack_ctrl.sv
module lrx_ack_ctrl #(
  parameter int HOLD_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic full,
  input  logic word_vld,
  input  logic word_long,
  output logic ack
);

  localparam int HW = $clog2(HOLD_CYC + 1);

  logic [HW-1:0] hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      hold <= '0;
    else if (word_vld && word_long)  hold <= HW'(HOLD_CYC);
    else if (hold != '0)             hold <= hold - 1'b1;
  end

  assign ack = enable & ~full & (hold == '0);

  p_hold_after_long_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld && word_long) |=> !ack);

endmodule

// File: rtl/link_rx_ack.sv
module link_rx_ack #(
  parameter int LONG_W      = 48,
  parameter int SHORT_W     = 32,
  parameter int UNIT_W      = 8,
  parameter int NARROW_W    = 4,
  parameter int SYNC_STAGES = 2,
  parameter int BUF_DEPTH   = 2,
  parameter int HOLD_CYC    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic              cfg_long_word,
  input  logic              cfg_wide_path,
  input  logic              dma_active,
  input  logic              lnk_clk,
  input  logic [UNIT_W-1:0] lnk_data,
  output logic              lnk_ack,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [LONG_W-1:0] rd_data,
  output logic              rd_empty,
  output logic              srq
);

  logic              fall_stb;
  logic [UNIT_W-1:0] unit_data;
  logic              word_vld, word_long;
  logic [LONG_W-1:0] word_data;
  logic              buf_full;

  lrx_edge_sync #(.STAGES(SYNC_STAGES), .UNIT_W(UNIT_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .lnk_clk(lnk_clk), .lnk_data(lnk_data),
    .fall_stb(fall_stb), .unit_data(unit_data)
  );

  lrx_assembler #(.LONG_W(LONG_W), .SHORT_W(SHORT_W), .UNIT_W(UNIT_W),
                  .NARROW_W(NARROW_W)) u_asm (
    .clk(clk), .rst_n(rst_n), .enable(cfg_enable), .long_word(cfg_long_word),
    .wide_path(cfg_wide_path), .unit_stb(fall_stb), .unit_data(unit_data),
    .word_vld(word_vld), .word_long(word_long), .word_data(word_data)
  );

  lrx_fifo2 #(.WIDTH(LONG_W), .DEPTH(BUF_DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_n), .push(word_vld), .push_data(word_data),
    .out_valid(rd_valid), .out_ready(rd_ready), .out_data(rd_data),
    .full(buf_full), .empty(rd_empty)
  );

  lrx_ack_ctrl #(.HOLD_CYC(HOLD_CYC)) u_ack (
    .clk(clk), .rst_n(rst_n), .enable(cfg_enable), .full(buf_full),
    .word_vld(word_vld), .word_long(word_long), .ack(lnk_ack)
  );

  assign srq = rd_valid & ~dma_active;

  p_srq_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dma_active |-> !srq);

endmodule

// File: tb/sim_link_rx_ack.sv
module sim_link_rx_ack;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_enable = 1'b1, cfg_long_word = 1'b0, cfg_wide_path = 1'b0;
  logic        dma_active = 1'b0;
  logic        lnk_clk = 1'b0;
  logic [7:0]  lnk_data = '0;
  logic        lnk_ack, rd_valid, rd_ready = 1'b0, rd_empty, srq;
  logic [47:0] rd_data;

  int checks = 0, fails = 0, lows = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  link_rx_ack u0 (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable),
    .cfg_long_word(cfg_long_word), .cfg_wide_path(cfg_wide_path),
    .dma_active(dma_active), .lnk_clk(lnk_clk), .lnk_data(lnk_data),
    .lnk_ack(lnk_ack), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .rd_empty(rd_empty), .srq(srq)
  );

  task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_ack();
    while (lnk_ack !== 1'b1) @(negedge clk);
  endtask

  // sends nunits units of word, most significant first; counts ack-low cycles after the final fall
  task automatic send_units(input logic [47:0] word, input bit lng, input bit wide, input int nunits);
    int uw = wide ? 8 : 4;
    int total = (lng ? 48 : 32) / uw;
    cfg_long_word = lng;
    cfg_wide_path = wide;
    wait_ack();
    lows = 0;
    for (int k = 0; k < nunits; k++) begin
      logic [47:0] sh = word >> ((total - 1 - k) * uw);
      lnk_clk = 1'b1;
      lnk_data = wide ? sh[7:0] : {4'h0, sh[3:0]};
      repeat (4) @(negedge clk);
      lnk_clk = 1'b0;
      for (int c = 0; c < ((k == nunits - 1) ? 30 : 4); c++) begin
        @(negedge clk);
        if (k == nunits - 1 && lnk_ack === 1'b0) lows++;
      end
    end
  endtask

  task automatic read_word(output logic [47:0] val);
    while (rd_valid !== 1'b1) @(negedge clk);
    val = rd_data;
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 ack", lnk_ack, 1);
    check("R1 valid", rd_valid, 0);
    check("R1 empty", rd_empty, 1);
    check("R1 srq", srq, 0);
  endtask

  task automatic t_narrow32();
    logic [47:0] v;
    send_units(48'h0000_A1B2_C3D4, 0, 0, 8);
    check("R7 no hold on short word", lows, 0);
    check("R10 empty low", rd_empty, 0);
    read_word(v);
    check("R3 nibble order", v, 48'h0000_A1B2_C3D4);
    check("R10 empty after read", rd_empty, 1);
  endtask

  task automatic t_sizes();
    logic [47:0] v;
    send_units(48'h0000_DEAD_BEEF, 0, 1, 4);
    read_word(v);
    check("R4 byte path 32", v, 48'h0000_DEAD_BEEF);
    send_units(48'h1234_5678_9ABC, 1, 1, 6);
    check("R7 hold after long word", lows, 2);
    read_word(v);
    check("R4 byte path 48", v, 48'h1234_5678_9ABC);
    send_units(48'hFEDC_BA98_7654, 1, 0, 12);
    check("R7 hold after long nibble word", lows, 2);
    read_word(v);
    check("R4 nibble path 48", v, 48'hFEDC_BA98_7654);
  endtask

  task automatic t_glitch();
    logic [47:0] v;
    cfg_long_word = 0; cfg_wide_path = 1;
    wait_ack();
    for (int k = 0; k < 4; k++) begin
      lnk_clk = 1'b1;
      lnk_data = 8'hFF;
      repeat (2) @(negedge clk);
      lnk_data = 8'h10 + 8'(k);
      repeat (3) @(negedge clk);
      lnk_clk = 1'b0;
      repeat (5) @(negedge clk);
    end
    repeat (10) @(negedge clk);
    read_word(v);
    check("R2 high-phase data ignored", v, 48'h0000_1011_1213);
  endtask

  task automatic t_full();
    logic [47:0] v;
    send_units(48'h0000_1111_2222, 0, 1, 4);
    send_units(48'h0000_3333_4444, 0, 1, 4);
    check("R5 ack low when full", lnk_ack, 0);
    repeat (3) @(negedge clk);
    check("R6 head held", rd_data, 48'h0000_1111_2222);
    read_word(v);
    check("R5 first out", v, 48'h0000_1111_2222);
    check("R5 ack back", lnk_ack, 1);
    read_word(v);
    check("R5 second out", v, 48'h0000_3333_4444);
  endtask

  task automatic t_stall();
    logic [47:0] v;
    rd_ready = 1'b1;
    repeat (5) @(negedge clk);
    check("R6 no valid when empty", rd_valid, 0);
    rd_ready = 1'b0;
    send_units(48'h0000_5A5A_C3C3, 0, 1, 4);
    dma_active = 1'b1;
    @(negedge clk);
    check("R8 srq masked", srq, 0);
    dma_active = 1'b0;
    @(negedge clk);
    check("R8 srq raised", srq, 1);
    read_word(v);
    check("R6 word after empty reads", v, 48'h0000_5A5A_C3C3);
    check("R6 buffer drained", rd_empty, 1);
    check("R8 srq cleared", srq, 0);
  endtask

  task automatic t_disable();
    logic [47:0] v;
    send_units(48'h0000_7777_7777, 0, 0, 3);
    cfg_enable = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 ack low when disabled", lnk_ack, 0);
    check("R9 nothing stored", rd_empty, 1);
    cfg_enable = 1'b1;
    @(negedge clk);
    send_units(48'h0000_0123_4567, 0, 0, 8);
    read_word(v);
    check("R9 partial discarded", v, 48'h0000_0123_4567);
    check("R9 single word", rd_empty, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_narrow32();
    t_sizes();
    t_glitch();
    t_full();
    t_stall();
    t_disable();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule